// File: doc/BRIEF.md
# Dual-Polynomial Self-Synchronizing Line Descrambler

This block sits in a serial line receive path. Each accepted bit is descrambled by XORing it with two earlier line bits held in a 23-stage history register. The register is filled with the received (scrambled) line bits, never with the block's output. Because of this, the block locks onto any scrambler state once 23 payload bits have passed. No seed or alignment step is needed.

A run-time select input picks one of two feedback polynomials. Both polynomials share the same history. Setting the select low chooses x^-23 + x^-18 + 1, used on the remote-to-central link. Setting it high chooses x^-23 + x^-5 + 1, used on the central-to-remote link.

An upstream framer flags the frame's overhead bits (the 14-bit sync word and the 4 stuff bits). These bits are forwarded untouched and are kept out of the history. An enable input turns the descrambling off for transparent bypass. While bypassed, the history keeps loading the line bits, so the block is already locked when it is re-enabled. The result is registered, so each output appears one clock after its input.

Top module: `line_descrambler`

## Requirements
- R1: While rst_ni is low, bit_o and bit_vld_o are 0 and the history is cleared to all zeros. After reset, the first enabled payload bits are therefore output equal to the input until 1s reach the tapped stages.
- R2: bit_vld_o equals bit_vld_i of the previous clock. When bit_vld_i is low, bit_o keeps its previous value.
- R3: With tap_sel_i = 0, dscr_en_i = 1 and skip_i = 0, an accepted bit leaves as bit_i XOR (line bit 18 accepted payload bits earlier) XOR (line bit 23 accepted payload bits earlier).
- R4: With tap_sel_i = 1, dscr_en_i = 1 and skip_i = 0, an accepted bit leaves as bit_i XOR (line bit 5 payload bits earlier) XOR (line bit 23 payload bits earlier).
- R5: The history loads the received line bit rather than the output. A stream scrambled by the matching multiplicative scrambler, from any starting state, is recovered exactly from the 24th payload bit onward.
- R6: An accepted bit with skip_i = 1 is output unchanged and does not enter the history. Payload descrambling across an overhead field continues as if the field were absent.
- R7: With dscr_en_i = 0, accepted bits are output unchanged, but payload bits still shift into the history.
- R8: Cycles with bit_vld_i = 0 leave the history unchanged.
- R9: Changing tap_sel_i between two payload bits takes effect on the very next bit, using the same shared history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Line bit present this cycle |
| bit_i | input | 1 | Received line bit |
| skip_i | input | 1 | Bit is framing overhead (sync or stuff) |
| dscr_en_i | input | 1 | 1 = descramble, 0 = pass through |
| tap_sel_i | input | 1 | 0 = taps 18/23, 1 = taps 5/23 |
| bit_o | output | 1 | Descrambled bit |
| bit_vld_o | output | 1 | bit_o is valid |

## Verification
The hardest case to reach is an overhead field, or an idle gap, that falls inside a payload run. Here the history must freeze across the field, and the descrambled payload on the far side must still match the original data. A bench-side scrambler, started from a nonzero state, produces a stream with a 14-bit sync field spliced into its middle. The payload is checked bit-exact both before and after that field. The stimulus table also places polynomial switches and bypass segments directly next to each other, so every transition is checked against a bench reference history.

// File: rtl/desc_pkg.sv
package desc_pkg;
  localparam int unsigned DEF_HIST_LEN  = 23;
  localparam int unsigned DEF_SHORT_UP  = 18;
  localparam int unsigned DEF_SHORT_DN  = 5;

  typedef enum logic {
    TAP_UPSTREAM   = 1'b0,
    TAP_DOWNSTREAM = 1'b1
  } tap_sel_e;
endpackage

// File: rtl/desc_history.sv
module desc_history #(
  parameter int unsigned LEN = 23
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_i,
  input  logic           bit_i,
  output logic [LEN-1:0] hist_o
);
  logic [LEN-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[LEN-2:0], bit_i};
  end

  assign hist_o = hist_q;

  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_o)); // R8
endmodule

// File: rtl/desc_taps.sv
module desc_taps import desc_pkg::*; #(
  parameter int unsigned LEN      = 23,
  parameter int unsigned SHORT_UP = 18,
  parameter int unsigned SHORT_DN = 5
) (
  input  logic [LEN-1:0] hist_i,
  input  tap_sel_e       sel_i,
  output logic           fb_o
);
  localparam logic [LEN-1:0] LONG_BIT = {1'b1, {(LEN-1){1'b0}}};
  localparam logic [LEN-1:0] MASK_UP  = LONG_BIT | (LEN'(1) << (SHORT_UP - 1));
  localparam logic [LEN-1:0] MASK_DN  = LONG_BIT | (LEN'(1) << (SHORT_DN - 1));

  logic [LEN-1:0] mask;

  generate
    if (SHORT_UP == SHORT_DN) begin : g_single
      assign mask = MASK_UP;
      logic unused_sel;
      assign unused_sel = sel_i;
    end else begin : g_dual
      assign mask = (sel_i == TAP_DOWNSTREAM) ? MASK_DN : MASK_UP;
    end
  endgenerate

  assign fb_o = ^(hist_i & mask);
endmodule

// File: rtl/desc_out_stage.sv
module desc_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic bit_i,
  output logic bit_o,
  output logic vld_o
);
  logic bit_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) bit_q <= bit_i;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/line_descrambler.sv
module line_descrambler import desc_pkg::*; #(
  parameter int unsigned HIST_LEN = DEF_HIST_LEN,
  parameter int unsigned SHORT_UP = DEF_SHORT_UP,
  parameter int unsigned SHORT_DN = DEF_SHORT_DN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic skip_i,
  input  logic dscr_en_i,
  input  logic tap_sel_i,
  output logic bit_o,
  output logic bit_vld_o
);
  logic [HIST_LEN-1:0] hist;
  logic                shift_en;
  logic                fb;
  logic                pay_bit;

  // overhead bits never enter the history; bypass still loads it
  assign shift_en = bit_vld_i & ~skip_i;

  desc_history #(.LEN(HIST_LEN)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .bit_i  (bit_i),
    .hist_o (hist)
  );

  desc_taps #(.LEN(HIST_LEN), .SHORT_UP(SHORT_UP), .SHORT_DN(SHORT_DN)) u_taps (
    .hist_i(hist),
    .sel_i (tap_sel_e'(tap_sel_i)),
    .fb_o  (fb)
  );

  assign pay_bit = (dscr_en_i && !skip_i) ? (bit_i ^ fb) : bit_i;

  desc_out_stage u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (bit_vld_i),
    .bit_i (pay_bit),
    .bit_o (bit_o),
    .vld_o (bit_vld_o)
  );

  AST_VLD_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i |=> bit_vld_o); // R2
  AST_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> (!bit_vld_o && $stable(bit_o))); // R2
  AST_SKIP_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && skip_i) |=> (bit_o == $past(bit_i))); // R6
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && !dscr_en_i) |=> (bit_o == $past(bit_i))); // R7
  AST_TAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && !skip_i && dscr_en_i && !tap_sel_i) |=>
      (bit_o == $past(bit_i ^ hist[SHORT_UP-1] ^ hist[HIST_LEN-1]))); // R3
  AST_TAP_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && !skip_i && dscr_en_i && tap_sel_i) |=>
      (bit_o == $past(bit_i ^ hist[SHORT_DN-1] ^ hist[HIST_LEN-1]))); // R4
endmodule

// File: tb/line_descrambler_bench.sv
module line_descrambler_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_vld_i = 1'b0, bit_i = 1'b0, skip_i = 1'b0, dscr_en_i = 1'b0, tap_sel_i = 1'b0;
  logic bit_o, bit_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [22:0] m_hist = '0;
  logic        m_prev = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  line_descrambler u_line_descrambler (
    .clk_i(clk), .rst_ni(rst_ni), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .skip_i(skip_i), .dscr_en_i(dscr_en_i), .tap_sel_i(tap_sel_i),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o)
  );

  // fields: [11:4] length, [3] valid, [2] skip, [1] enable, [0] tap select
  localparam int NSEG = 8;
  localparam logic [11:0] SEG [NSEG] = '{
    {8'd30, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'd30, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'd14, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'd10, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'd20, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'd4,  1'b1, 1'b1, 1'b1, 1'b0},
    {8'd25, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd30, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  function automatic logic next_rand();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng[0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    bit_vld_i = 1'b0;
    m_hist = '0;
    m_prev = 1'b0;
    repeat (2) @(negedge clk);
    chk(bit_o == 1'b0, "R1 bit_o in reset", bit_o, 1'b0);
    chk(bit_vld_o == 1'b0, "R1 bit_vld_o in reset", bit_vld_o, 1'b0);
    rst_ni = 1'b1;
  endtask

  // drive at negedge, compare after the capturing posedge
  task automatic step(input logic v, input logic s, input logic e, input logic t,
                      input logic b, input string req, output logic got);
    logic exp;
    exp = (s || !e) ? b : (b ^ m_hist[t ? 4 : 17] ^ m_hist[22]);
    bit_vld_i = v; skip_i = s; dscr_en_i = e; tap_sel_i = t; bit_i = b;
    @(posedge clk);
    @(negedge clk);
    got = bit_o;
    if (v) begin
      chk(bit_vld_o == 1'b1, {req, " R2 valid"}, bit_vld_o, 1'b1);
      chk(bit_o == exp, req, bit_o, exp);
      m_prev = exp;
      if (!s) m_hist = {m_hist[21:0], b};
    end else begin
      chk(bit_vld_o == 1'b0, "R2 valid low", bit_vld_o, 1'b0);
      chk(bit_o == m_prev, "R8 output held in gap", bit_o, m_prev);
    end
    bit_vld_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic got;
    logic [22:0] s_hist;
    logic [59:0] payload;
    logic [59:0] line;
    do_reset();

    // R1: cleared history, first enabled bits pass as-is
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R1 cleared history", got);

    // table walk: R3, R4, R6, R7, R8, R9
    for (int sg = 0; sg < NSEG; sg++) begin
      string req;
      if (SEG[sg][2])       req = "R6 overhead pass";
      else if (!SEG[sg][1]) req = "R7 bypass";
      else if (SEG[sg][0])  req = "R4 taps 5/23 (R9 switch)";
      else                  req = "R3 taps 18/23 (R9 switch)";
      for (int i = 0; i < int'(SEG[sg][11:4]); i++)
        step(SEG[sg][3], SEG[sg][2], SEG[sg][1], SEG[sg][0], next_rand(), req, got);
    end

    // R5: self-synchronization against a bench scrambler, with R6 sync field mid-stream
    do_reset();
    s_hist = 23'h5A_3C71;
    for (int i = 0; i < 60; i++) begin
      payload[i] = next_rand();
      line[i] = payload[i] ^ s_hist[4] ^ s_hist[22];
      s_hist = {s_hist[21:0], line[i]};
    end
    for (int i = 0; i < 60; i++) begin
      if (i == 40) begin
        for (int k = 0; k < 14; k++) begin
          logic sb;
          sb = next_rand();
          step(1'b1, 1'b1, 1'b1, 1'b1, sb, "R6 sync field in stream", got);
          chk(got == sb, "R6 sync bit unchanged", got, sb);
        end
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R8 gap", got);
      end
      step(1'b1, 1'b0, 1'b1, 1'b1, line[i], "R4 model", got);
      if (i >= 23) chk(got == payload[i], "R5 recovered payload", got, payload[i]);
    end

    // R1: reset mid-stream clears outputs and history
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R1 history cleared again", got);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule